// File: doc/BRIEF.md
# Page Access Check and Fault Reporter

This block decides whether one memory access may go ahead under the attributes of the page it targets. When the access is refused, it reports a page fault in the form an exception handler expects. Each strobed access supplies three page attribute bits: whether the page is present, whether it is writable, and whether user code may use it. It also supplies the access kind (read, write or instruction fetch), the current privilege level and the virtual address.

One clock edge after the strobe, the block answers with exactly one of two pulses. The grant pulse means the access may go ahead. The fault pulse comes with the page-fault vector number. On a fault the block also loads a three-bit error code and captures the faulting virtual address. Both values stay readable until the next fault replaces them.

The block is placed between the translation lookup and the memory request path. Delivery of the exception and pushing the error code onto a stack are left to the surrounding logic.

Top module: `pag_access_guard`

## Requirements
- R1: An access to a page whose present bit is 0 faults, whatever the other attributes, the kind or the privilege level. Its error code bit 0 is 0.
- R2: At privilege level 3 (user), an access to a present page whose user bit is 0 faults. Its error code bit 0 is 1.
- R3: At privilege level 3, a write to a present, user-accessible page whose writable bit is 0 faults. Its error code bit 0 is 1.
- R4: At privilege levels 0, 1 and 2 (supervisor), any access to a present page is granted, including a write to a read-only page.
- R5: Access kind is encoded as 0 read, 1 write, 2 fetch. Code 3 is also treated as a read. Only kind 1 is checked as a write, so a user fetch or read of a present, user, read-only page is granted.
- R6: Error code bit 1 is 1 exactly when the faulting access was a write (kind 1). Bit 2 is 1 exactly when the privilege level was 3. Bits 31 to 3 are always 0.
- R7: While the fault pulse is high, the vector output reads 0x0E. While it is low, the vector output reads 0.
- R8: On each fault, the fault-address register loads the strobed virtual address. It keeps its value through granted accesses and idle cycles until the next fault. The error code output holds in the same way.
- R9: Grant and fault are one-cycle pulses, registered one edge after the strobe. Exactly one of them is high for each strobe, and neither is high in a cycle that follows an edge without a strobe.
- R10: After reset, grant, fault, the vector, the error code and the fault address all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one access per high cycle |
| pg_present | input | 1 | Page present attribute |
| pg_writable | input | 1 | Effective writable attribute |
| pg_user | input | 1 | Effective user-accessible attribute |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| cur_priv | input | 2 | Current privilege level, 3 is user |
| vaddr | input | 32 | Virtual address of the access |
| grant | output | 1 | Access allowed pulse |
| fault | output | 1 | Page-fault pulse |
| fault_vector | output | 8 | Exception vector while fault is high, else 0 |
| fault_code | output | 32 | Error code of the most recent fault |
| fault_addr | output | 32 | Virtual address of the most recent fault |

## Verification
Every result leaves a register written at the same edge that samples the strobe. So grant, fault and the vector are due one edge after the strobe, and the error code and fault address change at that same edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares all five outputs on the next falling edge against values from its own model functions. Idle cycles with changing inputs are checked the same way: they must show no pulse, and the held error code and address must not move.

// File: rtl/pag_pkg.sv
package pag_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_SPARE = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic present;
      logic writable;
      logic user_ok;
   } page_attr_t;

   typedef struct packed {
      logic allow;
      logic is_write;
      logic is_user;
      logic present;
   } verdict_t;

   localparam int unsigned CODE_BIT_PROT  = 0;
   localparam int unsigned CODE_BIT_WRITE = 1;
   localparam int unsigned CODE_BIT_USER  = 2;

endpackage

// File: rtl/pag_rule_eval.sv
module pag_rule_eval
   import pag_pkg::*;
#(
   parameter int unsigned PRIV_W     = 2,
   parameter int unsigned USER_LEVEL = 3,
   parameter bit          WP_SUPER   = 1'b0
) (
   input  page_attr_t         attr,
   input  acc_kind_e          kind,
   input  logic [PRIV_W-1:0]  priv,
   output verdict_t           verdict
);

   localparam logic [PRIV_W-1:0] USER_CODE = PRIV_W'(USER_LEVEL);

   logic is_user;
   logic is_write;
   logic user_block;
   logic write_block;

   assign is_user  = (priv == USER_CODE);
   assign is_write = (kind == ACC_WRITE);

   assign user_block = is_user && !attr.user_ok;

   generate
      if (WP_SUPER) begin : g_wp_all
         assign write_block = is_write && !attr.writable;
      end else begin : g_wp_user
         assign write_block = is_write && !attr.writable && is_user;
      end
   endgenerate

   always_comb begin
      verdict          = '0;
      verdict.is_write = is_write;
      verdict.is_user  = is_user;
      verdict.present  = attr.present;
      verdict.allow    = attr.present && !user_block && !write_block;
   end

endmodule

// File: rtl/pag_code_build.sv
module pag_code_build
   import pag_pkg::*;
#(
   parameter int unsigned CODE_W = 32
) (
   input  verdict_t            verdict,
   output logic [CODE_W-1:0]   code
);

   always_comb begin
      code                 = '0;
      code[CODE_BIT_PROT]  = verdict.present;
      code[CODE_BIT_WRITE] = verdict.is_write;
      code[CODE_BIT_USER]  = verdict.is_user;
   end

endmodule

// File: rtl/pag_resp_reg.sv
module pag_resp_reg
   import pag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CODE_W = 32,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned VECTOR = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe,
   input  logic               allow,
   input  logic [CODE_W-1:0]  code_in,
   input  logic [ADDR_W-1:0]  addr_in,
   output logic               grant,
   output logic               fault,
   output logic [VEC_W-1:0]   vector,
   output logic [CODE_W-1:0]  code_q,
   output logic [ADDR_W-1:0]  addr_q
);

   localparam logic [VEC_W-1:0] VEC_CONST = VEC_W'(VECTOR);

   logic take_fault;
   assign take_fault = strobe && !allow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant  <= 1'b0;
         fault  <= 1'b0;
         vector <= '0;
      end else begin
         grant  <= strobe && allow;
         fault  <= take_fault;
         vector <= take_fault ? VEC_CONST : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         addr_q <= '0;
      end else if (take_fault) begin
         code_q <= code_in;
         addr_q <= addr_in;
      end
   end

endmodule

// File: rtl/pag_access_guard.sv
module pag_access_guard
   import pag_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CODE_W     = 32,
   parameter int unsigned PRIV_W     = 2,
   parameter int unsigned USER_LEVEL = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VECTOR     = 14,
   parameter bit          WP_SUPER   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               pg_present,
   input  logic               pg_writable,
   input  logic               pg_user,
   input  logic [1:0]         acc_kind,
   input  logic [PRIV_W-1:0]  cur_priv,
   input  logic [ADDR_W-1:0]  vaddr,
   output logic               grant,
   output logic               fault,
   output logic [VEC_W-1:0]   fault_vector,
   output logic [CODE_W-1:0]  fault_code,
   output logic [ADDR_W-1:0]  fault_addr
);

   localparam int unsigned PRIV_LEVELS = 1 << PRIV_W;
   localparam int unsigned VEC_LIMIT   = 1 << VEC_W;

   generate
      if (CODE_W < 3) begin : g_bad_code
         $error("CODE_W must hold three flag bits");
      end
      if (USER_LEVEL >= PRIV_LEVELS) begin : g_bad_user
         $error("USER_LEVEL exceeds the privilege field");
      end
      if (VECTOR >= VEC_LIMIT) begin : g_bad_vec
         $error("VECTOR does not fit VEC_W");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ADDR_W too small for a paged address");
      end
   endgenerate

   page_attr_t          attr;
   verdict_t            verdict;
   logic [CODE_W-1:0]   code_now;

   assign attr.present  = pg_present;
   assign attr.writable = pg_writable;
   assign attr.user_ok  = pg_user;

   pag_rule_eval #(
      .PRIV_W     (PRIV_W),
      .USER_LEVEL (USER_LEVEL),
      .WP_SUPER   (WP_SUPER)
   ) u_rules (
      .attr    (attr),
      .kind    (acc_kind_e'(acc_kind)),
      .priv    (cur_priv),
      .verdict (verdict)
   );

   pag_code_build #(
      .CODE_W (CODE_W)
   ) u_code (
      .verdict (verdict),
      .code    (code_now)
   );

   pag_resp_reg #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W),
      .VEC_W  (VEC_W),
      .VECTOR (VECTOR)
   ) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (req_valid),
      .allow   (verdict.allow),
      .code_in (code_now),
      .addr_in (vaddr),
      .grant   (grant),
      .fault   (fault),
      .vector  (fault_vector),
      .code_q  (fault_code),
      .addr_q  (fault_addr)
   );

endmodule

// File: rtl/pag_access_guard_chk.sv
module pag_access_guard_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CODE_W     = 32,
   parameter int unsigned PRIV_W     = 2,
   parameter int unsigned USER_LEVEL = 3,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned VECTOR     = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               pg_present,
   input logic [PRIV_W-1:0]  cur_priv,
   input logic [ADDR_W-1:0]  vaddr,
   input logic               grant,
   input logic               fault,
   input logic [VEC_W-1:0]   fault_vector,
   input logic [CODE_W-1:0]  fault_code,
   input logic [ADDR_W-1:0]  fault_addr
);

   // R9
   excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && fault));

   // R9
   one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (grant ^ fault));

   // R9
   no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!grant && !fault));

   // R1
   absent_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !pg_present) |=> (fault && !fault_code[0]));

   // R4
   super_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && pg_present && cur_priv != PRIV_W'(USER_LEVEL)) |=> grant);

   // R7
   vec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vector == (fault ? VEC_W'(VECTOR) : '0));

   // R6
   code_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_code[CODE_W-1:3] == '0);

   // R8
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !pg_present) |=> (fault_addr == $past(vaddr)));

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid) |=> $stable(fault_addr));

endmodule

bind pag_access_guard pag_access_guard_chk #(
   .ADDR_W     (ADDR_W),
   .CODE_W     (CODE_W),
   .PRIV_W     (PRIV_W),
   .USER_LEVEL (USER_LEVEL),
   .VEC_W      (VEC_W),
   .VECTOR     (VECTOR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .pg_present   (pg_present),
   .cur_priv     (cur_priv),
   .vaddr        (vaddr),
   .grant        (grant),
   .fault        (fault),
   .fault_vector (fault_vector),
   .fault_code   (fault_code),
   .fault_addr   (fault_addr)
);

// File: tb/sim_pag_access_guard.sv
`timescale 1ns/1ps
module sim_pag_access_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        pg_present = 1'b0;
   logic        pg_writable = 1'b0;
   logic        pg_user = 1'b0;
   logic [1:0]  acc_kind = 2'd0;
   logic [1:0]  cur_priv = 2'd0;
   logic [31:0] vaddr = 32'd0;
   logic        grant;
   logic        fault;
   logic [7:0]  fault_vector;
   logic [31:0] fault_code;
   logic [31:0] fault_addr;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] m_code = 32'd0;
   logic [31:0] m_addr = 32'd0;
   logic        done = 1'b0;

   always #2 clk = ~clk;

   pag_access_guard u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .pg_present(pg_present), .pg_writable(pg_writable), .pg_user(pg_user),
      .acc_kind(acc_kind), .cur_priv(cur_priv), .vaddr(vaddr),
      .grant(grant), .fault(fault), .fault_vector(fault_vector),
      .fault_code(fault_code), .fault_addr(fault_addr)
   );

   function automatic bit m_allow(bit p, bit w, bit u, logic [1:0] k, logic [1:0] pl);
      if (!p) return 1'b0;
      if (pl == 2'd3 && !u) return 1'b0;
      if (pl == 2'd3 && k == 2'd1 && !w) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [31:0] m_errc(bit p, logic [1:0] k, logic [1:0] pl);
      logic [31:0] c = 32'd0;
      c[0] = p;
      c[1] = (k == 2'd1);
      c[2] = (pl == 2'd3);
      return c;
   endfunction

   task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(string req, bit p, bit w, bit u, logic [1:0] k,
                         logic [1:0] pl, logic [31:0] a);
      bit ok;
      @(negedge clk);
      req_valid = 1'b1; pg_present = p; pg_writable = w; pg_user = u;
      acc_kind = k; cur_priv = pl; vaddr = a;
      ok = m_allow(p, w, u, k, pl);
      if (!ok) begin
         m_code = m_errc(p, k, pl);
         m_addr = a;
      end
      @(negedge clk);
      req_valid = 1'b0;
      cmp({req, " R9 grant"}, {31'd0, grant}, {31'd0, ok});
      cmp({req, " R9 fault"}, {31'd0, fault}, {31'd0, !ok});
      cmp({req, " R7 vector"}, {24'd0, fault_vector}, ok ? 32'd0 : 32'h0E);
      cmp({req, " R6 code"}, fault_code, m_code);
      cmp({req, " R8 addr"}, fault_addr, m_addr);
   endtask

   task automatic idle_check(logic [31:0] junk);
      pg_present = junk[0]; pg_writable = junk[1]; pg_user = junk[2];
      acc_kind = junk[4:3]; cur_priv = junk[6:5]; vaddr = junk;
      @(negedge clk);
      cmp("R9 idle grant", {31'd0, grant}, 32'd0);
      cmp("R9 idle fault", {31'd0, fault}, 32'd0);
      cmp("R8 idle code hold", fault_code, m_code);
      cmp("R8 idle addr hold", fault_addr, m_addr);
   endtask

   initial begin
      void'($urandom(32'h5eed_0e0e));
      repeat (3) @(negedge clk);
      // R10 reset state
      cmp("R10 grant", {31'd0, grant}, 32'd0);
      cmp("R10 fault", {31'd0, fault}, 32'd0);
      cmp("R10 vector", {24'd0, fault_vector}, 32'd0);
      cmp("R10 code", fault_code, 32'd0);
      cmp("R10 addr", fault_addr, 32'd0);
      rst_n = 1'b1;

      access("R1 absent super read", 0, 1, 1, 2'd0, 2'd0, 32'h0000_1234);
      access("R1 absent user write", 0, 1, 1, 2'd1, 2'd3, 32'hC000_0FFC);
      access("R2 user to super page", 1, 1, 0, 2'd0, 2'd3, 32'h0040_0008);
      access("R2 user fetch super page", 1, 0, 0, 2'd2, 2'd3, 32'h0040_2000);
      access("R3 user write ro", 1, 0, 1, 2'd1, 2'd3, 32'hB800_0010);
      access("R4 super write ro", 1, 0, 0, 2'd1, 2'd0, 32'h1111_0000);
      access("R4 level2 write ro", 1, 0, 1, 2'd1, 2'd2, 32'h2222_0000);
      access("R5 user fetch ro", 1, 0, 1, 2'd2, 2'd3, 32'h3333_0000);
      access("R5 user kind3 ro", 1, 0, 1, 2'd3, 2'd3, 32'h4444_0000);
      access("R8 granted keeps addr", 1, 1, 1, 2'd1, 2'd3, 32'h5555_0000);
      idle_check(32'hFFFF_FFFF);
      access("R6 absent fetch lvl1", 0, 0, 0, 2'd2, 2'd1, 32'hFFFF_F000);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] r = $urandom;
         access("R9 random", r[0], r[1], r[2], r[4:3], r[6:5], $urandom);
         if (r[9:7] == 3'd0) idle_check($urandom);
      end

      // back-to-back strobes
      @(negedge clk);
      req_valid = 1'b1; pg_present = 1'b0; cur_priv = 2'd3; acc_kind = 2'd1;
      vaddr = 32'hABCD_0001; pg_writable = 1'b0; pg_user = 1'b0;
      @(negedge clk);
      pg_present = 1'b1; pg_user = 1'b1; pg_writable = 1'b1;
      vaddr = 32'h0BAD_0002;
      m_code = 32'h6; m_addr = 32'hABCD_0001;
      cmp("R9 b2b fault", {31'd0, fault}, 32'd1);
      cmp("R6 b2b code", fault_code, m_code);
      @(negedge clk);
      req_valid = 1'b0;
      cmp("R9 b2b grant", {31'd0, grant}, 32'd1);
      cmp("R8 b2b addr hold", fault_addr, m_addr);
      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule